// File: doc/BRIEF.md
# Up-Counting Timer with Shadowed Period and Compare Output

This block is a general-purpose timer for a larger chip. A prescaler divides the system clock, and a 16-bit counter counts up from zero to a programmed period value. When the counter reaches that value it wraps to zero and raises an update flag. A single compare channel watches the counter. It can set, clear or toggle a reference level when a match occurs, or ignore the match. It can also produce pulse-width modulation from the counter and compare value. The pin level is the reference combined with a selectable polarity.

Software sees a small register port: a write strobe with an address and data, and a combinational read of the addressed register. The period register has an optional preload. With preload on, a written period waits in the visible register and is copied into the working (shadow) copy only at the next update event. With preload off, the copy happens right away. The prescaler divide value always waits for an update event. Writing the event register forces an update, which restarts the counter and prescaler and reloads both shadow values.

Top module: `pwm_timer`

## Requirements
- R1: After reset the counter reads 0, both flags are 0, the pin is low, the period register reads 0xFFFF and all other registers read 0.
- R2: With prescale value P in effect, the counter goes up by one every P+1 clocks in which `cnt_en` is high. It holds while `cnt_en` is low.
- R3: When the prescaler expires while the counter equals the working period, the counter goes to 0 on that clock and the update flag (FLAGS bit 0) is set.
- R4: With preload on (CTRL bit 0 = 1), a period written to address 1 takes effect only at the next update event. A prescale value written to address 2 always takes effect at an update event.
- R5: With preload off, a period written to address 1 becomes the working period on the next clock.
- R6: Writing address 5 with bit 0 = 1 forces an update event. The counter and prescaler restart from 0, both shadow values reload, and the update flag is set.
- R7: When the prescaler expires while the counter equals the compare value (address 3), the match flag (FLAGS bit 1) is set. Writing 1 to a FLAGS bit clears it, writing 0 leaves it unchanged, and a flag that is set and cleared on the same clock stays set.
- R8: CTRL bits 3:1 select the compare mode. 0 (and 5 to 7) ignores a match, 1 drives the reference high on a match, 2 drives it low, and 3 inverts it.
- R9: In mode 4 the reference is high while counter < compare and low otherwise. A compare value of 0 gives a constant low reference, and a compare value above the period gives a constant high one.
- R10: CTRL bit 4 = 1 inverts the pin relative to the reference.
- R11: The read map is: 0 = CTRL in bits 4:0, 1 = period register, 2 = prescale register, 3 = compare, 4 = flags, 6 = counter, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable for the prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| tmr_out | output | 1 | Compare output pin |
| upd_flag | output | 1 | Update flag |
| cmp_flag | output | 1 | Compare match flag |

## Verification
A wrong working period or prescale shadow shows up first in the counter readback and the update flag. The error appears at the next wrap, which comes one period early or late, so the check catches it within one counter period. A wrong reference state in the event-driven modes shows on the pin at the first match after the fault. In PWM mode a compare fault shows within the same counter period. The reference model runs beside the design and is compared on every clock, so a divergence is reported on the exact clock it reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRESC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_EVENT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;

    // compare modes
    localparam logic [2:0] OC_FROZEN = 3'd0;
    localparam logic [2:0] OC_SET    = 3'd1;
    localparam logic [2:0] OC_CLR    = 3'd2;
    localparam logic [2:0] OC_TOGGLE = 3'd3;
    localparam logic [2:0] OC_PWM    = 3'd4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] div_new,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] div_sh;
    } ps_t;

    ps_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = cnt_en && (s_q.cnt == s_q.div_sh);
        if (clear || tick)
            s_d.cnt = '0;
        else if (cnt_en)
            s_d.cnt = s_q.cnt + 1'b1;
        if (load)
            s_d.div_sh = div_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         match,
    input  logic [2:0]   mode,
    input  logic         pol,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    output logic         pin
);
    import tmr_pkg::*;

    typedef struct packed {
        logic lvl;
    } oc_t;

    oc_t  s_d, s_q;
    logic ref_lvl;

    always_comb begin
        s_d = s_q;
        if (match) begin
            case (mode)
                OC_SET:    s_d.lvl = 1'b1;
                OC_CLR:    s_d.lvl = 1'b0;
                OC_TOGGLE: s_d.lvl = ~s_q.lvl;
                default:   s_d.lvl = s_q.lvl;
            endcase
        end
        ref_lvl = (mode == OC_PWM) ? (count < cmp) : s_q.lvl;
        pin     = ref_lvl ^ pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             tmr_out,
    output logic             upd_flag,
    output logic             cmp_flag
);
    import tmr_pkg::*;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] psc;
        logic [CNT_W-1:0] cmp;
        logic             preload;
        logic [2:0]       mode;
        logic             pol;
        logic             updf;
        logic             cmpf;
    } tm_t;

    tm_t  s_d, s_q;
    logic tick, force_upd, wrap, match, upd_evt, clr_upd;
    logic [CNT_W-1:0] count_w, cmp_w;
    logic [2:0]       mode_w;
    logic             pol_w;

    assign count_w = s_q.cnt;
    assign cmp_w   = s_q.cmp;
    assign mode_w  = s_q.mode;
    assign pol_w   = s_q.pol;

    always_comb begin
        force_upd = wr_en && (addr == A_EVENT) && wdata[0];
        clr_upd   = wr_en && (addr == A_FLAGS) && wdata[0];
        wrap      = tick && !force_upd && (s_q.cnt == s_q.per_sh);
        match     = tick && !force_upd && (s_q.cnt == s_q.cmp);
        upd_evt   = force_upd || wrap;

        s_d = s_q;
        if (force_upd || wrap)
            s_d.cnt = '0;
        else if (tick)
            s_d.cnt = s_q.cnt + 1'b1;
        if (upd_evt)
            s_d.per_sh = s_q.per;

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    s_d.preload = wdata[0];
                    s_d.mode    = wdata[3:1];
                    s_d.pol     = wdata[4];
                end
                A_RELOAD: begin
                    s_d.per = wdata;
                    if (!s_q.preload)
                        s_d.per_sh = wdata;
                end
                A_PRESC: s_d.psc = wdata;
                A_CMP:   s_d.cmp = wdata;
                A_FLAGS: begin
                    if (wdata[0]) s_d.updf = 1'b0;
                    if (wdata[1]) s_d.cmpf = 1'b0;
                end
                default: ;
            endcase
        end
        if (upd_evt) s_d.updf = 1'b1;
        if (match)   s_d.cmpf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.per    <= '1;
            s_q.per_sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    tmr_prescale #(.W(CNT_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .clear   (force_upd),
        .load    (upd_evt),
        .div_new (s_q.psc),
        .tick    (tick)
    );

    tmr_compare #(.W(CNT_W)) u_oc (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .mode  (mode_w),
        .pol   (pol_w),
        .count (count_w),
        .cmp   (cmp_w),
        .pin   (tmr_out)
    );

    always_comb begin
        case (addr)
            A_CTRL:   rdata = CNT_W'({pol_w, mode_w, s_q.preload});
            A_RELOAD: rdata = s_q.per;
            A_PRESC:  rdata = s_q.psc;
            A_CMP:    rdata = cmp_w;
            A_FLAGS:  rdata = CNT_W'({s_q.cmpf, s_q.updf});
            A_COUNT:  rdata = count_w;
            default:  rdata = '0;
        endcase
    end

    assign upd_flag = s_q.updf;
    assign cmp_flag = s_q.cmpf;

    // unused-width guard for the control field size
    if (CTRL_W > CNT_W) begin : g_bad_width
        initial $display("control field wider than data path");
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             force_upd,
    input logic             clr_upd,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp,
    input logic [2:0]       mode,
    input logic             pol,
    input logic             upd_flag,
    input logic             tmr_out
);
    // R2: counter moves only by one step or back to zero
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));

    // R2: without enable or forced update the counter holds
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !force_upd) |=> $stable(count));

    // R3: update flag rises only together with a restarted counter
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_flag) |-> (count == '0));

    // R6: a forced update restarts the counter
    p_force_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (count == '0 && upd_flag));

    // R7: a set update flag persists unless cleared by software
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !clr_upd) |=> upd_flag);

    // R9: zero compare in PWM mode keeps the reference low
    p_pwm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && cmp == '0) |-> (tmr_out == pol));
endmodule

bind pwm_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .force_upd (force_upd),
    .clr_upd   (clr_upd),
    .count     (count_w),
    .cmp       (cmp_w),
    .mode      (mode_w),
    .pol       (pol_w),
    .upd_flag  (upd_flag),
    .tmr_out   (tmr_out)
);

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd6;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        tmr_out, upd_flag, cmp_flag;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out),
        .upd_flag(upd_flag), .cmp_flag(cmp_flag)
    );

    // behavioural reference model
    int m_cnt = 0, m_pc = 0, m_per = 65535, m_persh = 65535;
    int m_psc = 0, m_pscsh = 0, m_cmp = 0, m_mode = 0;
    bit m_pre = 0, m_pol = 0, m_upd = 0, m_cmpf = 0, m_ref = 0;
    bit t_tick, t_force, t_match, t_wrap;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_per = 65535; m_persh = 65535;
            m_psc = 0; m_pscsh = 0; m_cmp = 0; m_mode = 0;
            m_pre = 0; m_pol = 0; m_upd = 0; m_cmpf = 0; m_ref = 0;
        end else begin
            t_tick  = cnt_en && (m_pc == m_pscsh);
            t_force = wr_en && addr == 3'd5 && wdata[0];
            t_match = t_tick && !t_force && m_cnt == m_cmp;
            t_wrap  = t_tick && !t_force && m_cnt == m_persh;
            if (t_force) begin
                m_cnt = 0; m_pc = 0;
            end else if (t_tick) begin
                m_pc = 0;
                m_cnt = t_wrap ? 0 : (m_cnt + 1) % 65536;
            end else if (cnt_en) begin
                m_pc = m_pc + 1;
            end
            if (t_force || t_wrap) begin
                m_persh = m_per; m_pscsh = m_psc;
            end
            if (t_match) begin
                if (m_mode == 1) m_ref = 1;
                else if (m_mode == 2) m_ref = 0;
                else if (m_mode == 3) m_ref = !m_ref;
            end
            if (wr_en) begin
                case (addr)
                    3'd0: begin m_pre = wdata[0]; m_mode = int'(wdata[3:1]); m_pol = wdata[4]; end
                    3'd1: begin if (!m_pre) m_persh = int'(wdata); m_per = int'(wdata); end
                    3'd2: m_psc = int'(wdata);
                    3'd3: m_cmp = int'(wdata);
                    3'd4: begin if (wdata[0]) m_upd = 0; if (wdata[1]) m_cmpf = 0; end
                    default: ;
                endcase
            end
            if (t_force || t_wrap) m_upd = 1;
            if (t_match) m_cmpf = 1;
        end
    end

    function automatic int exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {m_pol, m_mode[2:0], m_pre};
            3'd1: return m_per;
            3'd2: return m_psc;
            3'd3: return m_cmp;
            3'd4: return {m_cmpf, m_upd};
            3'd6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("pin", int'(tmr_out), int'(((m_mode == 4) ? (m_cnt < m_cmp) : m_ref) ^ m_pol));
            chk("update flag", int'(upd_flag), int'(m_upd));
            chk("match flag", int'(cmp_flag), int'(m_cmpf));
            chk("rdata", int'(rdata), exp_rdata(addr));
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step(1);
        wr_en = 1'b0; addr = 3'd6; wdata = 16'h0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        #1 started = 1;
        step(1);
        // R1 reset state, swept over all addresses
        for (int a = 0; a < 8; a++) begin addr = 3'(a); step(1); end
        // R11 register map readback
        cur_tag = "R11";
        wr(3'd3, 16'h0123);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0006);
        wr(3'd0, 16'h0000);
        for (int a = 0; a < 8; a++) begin addr = 3'(a); step(1); end
        // R5 immediate period, R2 counting, R3 wrap
        cur_tag = "R5";
        wr(3'd1, 16'd5);
        cur_tag = "R3";
        addr = 3'd6; cnt_en = 1'b1; step(14);
        cur_tag = "R2";
        wr(3'd2, 16'd2);
        step(30);
        cnt_en = 1'b0; step(6);
        cnt_en = 1'b1; step(10);
        // R7 flag clear and set-wins
        cur_tag = "R7";
        wr(3'd4, 16'h0001);
        addr = 3'd4; step(3);
        wr(3'd4, 16'h0003);
        step(25);
        wr(3'd4, 16'h0002);
        // R4 preload behaviour
        cur_tag = "R4";
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'd3);
        addr = 3'd6; step(20);
        wr(3'd2, 16'd0);
        step(12);
        // R6 forced update
        cur_tag = "R6";
        wr(3'd1, 16'd7);
        step(2);
        wr(3'd5, 16'h0001);
        step(20);
        // R8 event driven modes
        cur_tag = "R8";
        wr(3'd3, 16'd2);
        wr(3'd0, 16'h0002);
        step(10);
        wr(3'd0, 16'h0004);
        step(10);
        wr(3'd0, 16'h0006);
        step(20);
        wr(3'd0, 16'h0000);
        step(10);
        wr(3'd0, 16'h000E);
        step(10);
        // R9 PWM duty, including 0% and 100%
        cur_tag = "R9";
        wr(3'd0, 16'h0008);
        wr(3'd3, 16'd3);
        step(20);
        wr(3'd3, 16'd0);
        step(12);
        wr(3'd3, 16'd9);
        step(12);
        wr(3'd1, 16'd4);
        wr(3'd3, 16'd2);
        step(12);
        // R10 polarity
        cur_tag = "R10";
        wr(3'd0, 16'h0018);
        step(12);
        wr(3'd0, 16'h0016);
        step(20);
        cnt_en = 1'b0;
        step(2);
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        finish_run();
    end
endmodule